// File: doc/BRIEF.md
# Activate and Column Command Timing Guard

This block sits between a DDR2 command scheduler and the command issuer. Each cycle the scheduler presents one requested command, either a row activate, a column read, a column write or a precharge, together with a target bank. The guard answers on the same cycle with a ready flag that says whether the command is legal now. A command is issued on a rising clock edge where both valid and ready are high, and the guard records it in its per-bank and device-wide history.

The request port follows valid/ready rules. Ready is a combinational function of the presented command, bank and internal state, and does not depend on valid. A requester that sees ready low must hold the same command and bank until ready rises. The guard never reorders or drops requests; it only gates them. All timing limits arrive as clock counts on plain inputs and are expected to stay steady during traffic. Nanosecond limits are converted to clocks by rounding up, so 20 ns at a 3.75 ns clock becomes 6.

Each bank keeps an open-row flag and two down-counters: one for activate-to-activate spacing on that bank and one for activate-to-column delay. A shared counter spaces activates across the device. With eight banks a four-entry ring of activate cycle stamps enforces the rolling four-activate window; with four banks that check is not built.

Top module: `act_guard`

## Requirements
- R1: Command codes on `req_cmd` are 2'b00 activate, 2'b01 read, 2'b10 write, 2'b11 precharge. A command is issued only on a clock edge where `req_valid` and `req_ready` are both 1; `req_ready` does not depend on `req_valid`, and a cycle with `req_valid` low changes no state.
- R2: After reset every bank is closed and no activate history exists: an activate to any bank is ready and a read or write to any bank is not.
- R3: A read or write to a bank is ready only when that bank's row is open and at least max(tRCD - AL, 1) cycles have passed since its activate; when AL is at least tRCD the column command is ready on the cycle after the activate.
- R4: An activate to a bank is ready only when that bank's row is closed and at least tRC cycles have passed since the previous activate to it.
- R5: Any two activates are issued at least tRRD cycles apart.
- R6: With eight banks, an activate that would be the fifth within a window is ready only once at least tFAW cycles have passed since the oldest of the last four issued activates.
- R7: With four banks, no rolling-window limit applies to activates.
- R8: A precharge is always ready; once issued it closes the bank's row, and reads and writes to that bank are refused until a new activate is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command is being requested |
| req_cmd | input | 2 | Requested command code |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_ready | output | 1 | Requested command is legal this cycle |
| t_rc | input | TW | Same-bank activate spacing, clocks |
| t_rrd | input | TW | Device-wide activate spacing, clocks |
| t_faw | input | TW | Rolling four-activate window, clocks |
| t_rcd | input | TW | Activate-to-column delay, clocks |
| t_al | input | TW | Additive latency subtracted from the column delay, clocks |

## Verification
Ready is combinational, so its answer for a given command, bank and state is due in the same cycle the request is presented; the effect of an issued command on that answer is due from the cycle after the issuing edge, and a limit of n cycles lifts exactly n cycles after the activate. The bench drives each request just after a falling edge and samples ready one nanosecond later, before the next rising edge issues it, so every expected value is counted in whole cycles from the issuing edge. A table of one request per cycle walks the bank, spacing, delay and window limits through their last refused and first allowed cycles, and directed cases cover reset state, saturated column delay, valid-low cycles and the four-bank build.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_PRE = 2'b11
  } ag_cmd_e;

endpackage

// File: rtl/ag_gap_ctr.sv
// Saturating down-counter: load with (limit - 1) on an event, done when zero.
module ag_gap_ctr #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] load_val;

  assign load_val = (limit == '0) ? '0 : limit - 1'b1;
  assign done     = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ag_bank_timer.sv
// Per-bank state: open-row flag, same-bank activate spacing, column delay.
module ag_bank_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_hit,
  input  logic          pre_hit,
  input  logic [TW-1:0] rc_limit,
  input  logic [TW-1:0] rcd_limit,
  output logic          row_open,
  output logic          rc_done,
  output logic          rcd_done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
    end else if (act_hit) begin
      row_open <= 1'b1;
    end else if (pre_hit) begin
      row_open <= 1'b0;
    end
  end

  ag_gap_ctr #(.TW(TW)) u_rc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (act_hit),
    .limit (rc_limit),
    .done  (rc_done)
  );

  ag_gap_ctr #(.TW(TW)) u_rcd (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (act_hit),
    .limit (rcd_limit),
    .done  (rcd_done)
  );
endmodule

// File: rtl/ag_faw_window.sv
// Ring of the last WIN_ACTS activate stamps; the oldest live stamp gates the next one.
module ag_faw_window #(
  parameter int TW       = 6,
  parameter int WIN_ACTS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_fire,
  input  logic [TW-1:0] t_faw,
  output logic          faw_ok
);
  localparam int SW = TW + 1;
  localparam int PW = (WIN_ACTS > 1) ? $clog2(WIN_ACTS) : 1;

  logic [SW-1:0] now;
  logic [SW-1:0] stamp [WIN_ACTS];
  logic [WIN_ACTS-1:0] live;
  logic [PW-1:0] wp;
  logic [SW-1:0] win;
  logic [SW-1:0] oldest_age;

  assign win        = {1'b0, t_faw};
  assign oldest_age = now - stamp[wp];
  assign faw_ok     = !live[wp] || (oldest_age >= win);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now  <= '0;
      live <= '0;
      wp   <= '0;
      for (int i = 0; i < WIN_ACTS; i++) stamp[i] <= '0;
    end else begin
      now <= now + 1'b1;
      for (int i = 0; i < WIN_ACTS; i++) begin
        if (live[i] && ((now - stamp[i]) >= win)) live[i] <= 1'b0;
      end
      if (act_fire) begin
        stamp[wp] <= now;
        live[wp]  <= 1'b1;
        wp        <= (wp == PW'(WIN_ACTS - 1)) ? '0 : wp + 1'b1;
      end
    end
  end
endmodule

// File: rtl/act_guard.sv
module act_guard
  import act_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 6,
  localparam int BW       = $clog2(NUM_BANKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_cmd,
  input  logic [BW-1:0] req_bank,
  output logic          req_ready,
  input  logic [TW-1:0] t_rc,
  input  logic [TW-1:0] t_rrd,
  input  logic [TW-1:0] t_faw,
  input  logic [TW-1:0] t_rcd,
  input  logic [TW-1:0] t_al
);
  ag_cmd_e cmd;
  logic fire, fire_act, fire_pre;
  logic [TW-1:0] rcd_eff;
  logic [NUM_BANKS-1:0] row_open, rc_done, rcd_done;
  logic rrd_done, faw_ok;

  assign cmd      = ag_cmd_e'(req_cmd);
  assign fire     = req_valid && req_ready;
  assign fire_act = fire && (cmd == CMD_ACT);
  assign fire_pre = fire && (cmd == CMD_PRE);
  // Posted column commands shorten the delay by the additive latency.
  assign rcd_eff  = (t_rcd > t_al) ? t_rcd - t_al : '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (req_bank == BW'(b));
    ag_bank_timer #(.TW(TW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_hit   (fire_act && hit),
      .pre_hit   (fire_pre && hit),
      .rc_limit  (t_rc),
      .rcd_limit (rcd_eff),
      .row_open  (row_open[b]),
      .rc_done   (rc_done[b]),
      .rcd_done  (rcd_done[b])
    );
  end

  ag_gap_ctr #(.TW(TW)) u_rrd (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire_act),
    .limit (t_rrd),
    .done  (rrd_done)
  );

  if (NUM_BANKS >= 8) begin : g_faw
    ag_faw_window #(.TW(TW), .WIN_ACTS(4)) u_faw (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_fire (fire_act),
      .t_faw    (t_faw),
      .faw_ok   (faw_ok)
    );
  end else begin : g_no_faw
    logic [TW-1:0] faw_unused;
    assign faw_unused = t_faw;
    assign faw_ok     = 1'b1;
  end

  always_comb begin
    unique case (cmd)
      CMD_ACT: req_ready = !row_open[req_bank] && rc_done[req_bank]
                           && rrd_done && faw_ok;
      CMD_RD,
      CMD_WR:  req_ready = row_open[req_bank] && rcd_done[req_bank];
      default: req_ready = 1'b1;
    endcase
  end
endmodule

// File: rtl/act_guard_chk.sv
module act_guard_chk #(
  parameter int NUM_BANKS = 8,
  parameter int TW        = 6,
  localparam int BW       = $clog2(NUM_BANKS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_cmd,
  input logic [BW-1:0] req_bank,
  input logic          req_ready,
  input logic [TW-1:0] t_rc,
  input logic [TW-1:0] t_rrd,
  input logic [TW-1:0] t_rcd,
  input logic [TW-1:0] t_al
);
  logic fire, is_act, is_col, is_pre;
  logic [TW:0] al_plus1;
  logic [TW-1:0] rc_seen;

  assign fire     = req_valid && req_ready;
  assign is_act   = (req_cmd == 2'b00);
  assign is_col   = (req_cmd == 2'b01) || (req_cmd == 2'b10);
  assign is_pre   = (req_cmd == 2'b11);
  assign al_plus1 = {1'b0, t_al} + 1'b1;
  assign rc_seen  = t_rc;

  AST_PRE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> req_ready); // R8

  AST_OPEN_BLOCKS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_act) |=> !(is_act && req_ready && req_bank == $past(req_bank))); // R4

  AST_RRD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_act && t_rrd >= 2) |=> !(is_act && req_ready)); // R5

  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_pre) |=> !(is_col && req_ready && req_bank == $past(req_bank))); // R8

  AST_RCD_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_act && {1'b0, t_rcd} > al_plus1)
      |=> !(is_col && req_ready && req_bank == $past(req_bank))); // R3

  AST_RC_INPUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_act) |-> !$isunknown(rc_seen)); // R4
endmodule

bind act_guard act_guard_chk #(.NUM_BANKS(NUM_BANKS), .TW(TW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_cmd   (req_cmd),
  .req_bank  (req_bank),
  .req_ready (req_ready),
  .t_rc      (t_rc),
  .t_rrd     (t_rrd),
  .t_rcd     (t_rcd),
  .t_al      (t_al)
);

// File: tb/act_guard_tb.sv
module act_guard_tb;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = 2'b00;
  logic [2:0] req_bank = 3'd0;
  logic req_ready, req_ready4;
  logic [TW-1:0] t_rc = 6'd10, t_rrd = 6'd2, t_faw = 6'd16, t_rcd = 6'd4, t_al = 6'd1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  act_guard #(.NUM_BANKS(8), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_ready(req_ready), .t_rc(t_rc), .t_rrd(t_rrd),
    .t_faw(t_faw), .t_rcd(t_rcd), .t_al(t_al));

  act_guard #(.NUM_BANKS(4), .TW(TW)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank[1:0]), .req_ready(req_ready4), .t_rc(t_rc), .t_rrd(t_rrd),
    .t_faw(t_faw), .t_rcd(t_rcd), .t_al(t_al));

  // {cmd, bank, expected ready}; one request per cycle, valid held high.
  localparam logic [5:0] VEC [0:21] = '{
    {2'b01, 3'd0, 1'b0},  // 0  R2 read to closed bank
    {2'b00, 3'd0, 1'b1},  // 1  activate b0
    {2'b00, 3'd1, 1'b0},  // 2  R5 spacing
    {2'b01, 3'd0, 1'b0},  // 3  R3 delay 3 not yet met
    {2'b01, 3'd0, 1'b1},  // 4  R3 first legal read
    {2'b00, 3'd1, 1'b1},  // 5  activate b1
    {2'b00, 3'd0, 1'b0},  // 6  R4 row open
    {2'b00, 3'd2, 1'b1},  // 7  activate b2
    {2'b11, 3'd0, 1'b1},  // 8  R8 precharge b0
    {2'b10, 3'd0, 1'b0},  // 9  R8 write to closed bank
    {2'b00, 3'd0, 1'b0},  // 10 R4 same-bank spacing
    {2'b00, 3'd0, 1'b1},  // 11 R4 first legal reactivate
    {2'b00, 3'd3, 1'b0},  // 12 R5 spacing
    {2'b00, 3'd3, 1'b0},  // 13 R6 window
    {2'b00, 3'd3, 1'b0},  // 14 R6
    {2'b00, 3'd3, 1'b0},  // 15 R6
    {2'b00, 3'd3, 1'b0},  // 16 R6 last refused
    {2'b00, 3'd3, 1'b1},  // 17 R6 window lifts
    {2'b00, 3'd4, 1'b0},  // 18 R5 spacing
    {2'b00, 3'd4, 1'b0},  // 19 R6 window
    {2'b00, 3'd4, 1'b0},  // 20 R6
    {2'b00, 3'd4, 1'b1}   // 21 R6 window lifts
  };

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: ready=%0b expected %0b", what, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic [2:0] b);
    @(negedge clk);
    req_valid = v;
    req_cmd   = c;
    req_bank  = b;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R2: fresh state
    drive(1'b0, 2'b00, 3'd5);
    check(req_ready, 1'b1, "R2 activate after reset");
    drive(1'b0, 2'b01, 3'd5);
    check(req_ready, 1'b0, "R2 read after reset");

    do_reset();
    for (int i = 0; i < 22; i++) begin
      drive(1'b1, VEC[i][5:4], VEC[i][3:1]);
      check(req_ready, VEC[i][0], $sformatf("R3/R4/R5/R6/R8 vector %0d", i));
    end

    // R1: ready independent of valid; valid low issues nothing
    do_reset();
    t_rcd = 6'd1; t_al = 6'd0; t_rc = 6'd1; t_rrd = 6'd1;
    drive(1'b0, 2'b00, 3'd6);
    check(req_ready, 1'b1, "R1 ready with valid low");
    drive(1'b0, 2'b01, 3'd6);
    check(req_ready, 1'b0, "R1 no issue while valid low");
    drive(1'b1, 2'b00, 3'd6);
    check(req_ready, 1'b1, "R1 activate issued");
    drive(1'b1, 2'b01, 3'd6);
    check(req_ready, 1'b1, "R1 read after issued activate");

    // R3: additive latency beyond the delay saturates to one cycle
    do_reset();
    t_rcd = 6'd4; t_al = 6'd6;
    drive(1'b1, 2'b00, 3'd2);
    check(req_ready, 1'b1, "R3 activate b2");
    drive(1'b1, 2'b10, 3'd2);
    check(req_ready, 1'b1, "R3 write next cycle with AL above tRCD");

    // R7: four-bank build has no window; eight-bank build refuses
    do_reset();
    t_rc = 6'd1; t_rrd = 6'd1; t_faw = 6'd16; t_rcd = 6'd1; t_al = 6'd0;
    for (int b = 0; b < 4; b++) begin
      drive(1'b1, 2'b00, 3'(b));
      check(req_ready4, 1'b1, "R7 four-bank activate");
    end
    drive(1'b1, 2'b11, 3'd0);
    check(req_ready, 1'b1, "R8 precharge ready");
    drive(1'b1, 2'b00, 3'd0);
    check(req_ready4, 1'b1, "R7 fifth activate with four banks");
    check(req_ready, 1'b0, "R6 fifth activate with eight banks");

    @(negedge clk);
    req_valid = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule